// File: doc/BRIEF.md
# Ethernet PHY Management Register Bank

This block holds the basic management registers of an Ethernet PHY: the control word, the status word, two fixed identifier words, the local advertisement word and a view of the link partner's ability word. A management front end, such as a serial management frame decoder, reaches it through a flat register port: a 5-bit address, a 16-bit write word with a one-cycle write strobe, and a read strobe. Read data is combinational from the address, so it is valid in the same cycle as the read strobe, and the clock edge that ends that cycle performs any clear-on-read side effect.

On the core side the block takes event and handshake inputs: link good, jabber, remote fault, negotiation done, soft-reset done and negotiation started. It drives the control levels that the PHY core obeys. Strap inputs give the reset values of speed, duplex, negotiation enable and four advertisement bits. An active-low power-down pin and a fiber-mode input act on the control word as well.

Command bits clear themselves when the core answers. Status bits hold an event until software reads them. The speed and duplex bits cannot be changed while negotiation is enabled.

Top module: `phy_mgmt_regs`

## Requirements
- R1: After reset, the control word (address 0) reads {0, 0, speed strap, negotiation strap AND NOT fiber, 0, 0, 0, duplex strap, 8'h00}, the advertisement word (address 4) reads {7'b0, advertisement straps[3:0], 5'b00001}, and the latched status bits read 0.
- R2: Writing 1 to control bit 15 raises the soft-reset output, and bit 15 reads 1 until the core pulses reset done. On that edge bit 15 clears, and the control and advertisement words reload their strap reset values.
- R3: Control bit 9 (negotiation restart) is set by a write with bit 9 = 1 only when bit 12 of that same write is 1 and fiber mode is off. It stays 1 until the core pulses negotiation started, and writing 0 to it does not clear it.
- R4: While the stored negotiation enable (bit 12) is 1, writes do not change the speed bit (13) or the duplex bit (8). While it is 0, those bits take the written value and drive the 100 Mb/s and full-duplex outputs directly.
- R5: The power-down output is control bit 11 OR the inverted power-down pin. A low pin also sets bit 11, which stays set after the pin returns high.
- R6: While the fiber-mode input is 1, negotiation enable is held at 0, whether it would come from a write or from the strap reload.
- R7: Status bit 2 (link) latches low. A cycle without link good clears it. It becomes 1 only on a status read made while link good is 1.
- R8: Status bits 1 (jabber) and 4 (remote fault) latch high on their event and clear after a status read. An event in the same cycle as the read keeps the bit at 1.
- R9: The status word (address 1) reads fixed bits 15 = 0, 14..11 = 1, 10..8 = 0, 7 = 1, 6 = 1, 3 = 1 and 0 = 1, and bit 5 follows negotiation done live.
- R10: Address 2 reads 16'h2000 and address 3 reads 16'h5CE1, made of OUI tail 6'b010111, model 6'h0E and revision 4'h1 from the most significant bit down.
- R11: In the advertisement word only bits 15, 13, 11, 10 and 8..0 are writable. Bits 14, 12 and 9 read 0. Writes to the status and identifier words are ignored.
- R12: Address 5 returns the link partner word input unchanged, and addresses 6 to 31 read 0.
- R13: Control bits 14 (loopback), 10 (isolate) and 7 (collision test) are plain read/write bits that drive their outputs. Control bits 6..0 ignore writes and read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 5 | Register address |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rd | input | 1 | Read strobe; clear-on-read happens at the edge that ends it |
| reg_wdata | input | 16 | Write word |
| reg_rdata | output | 16 | Read word for reg_addr (combinational) |
| core_link_ok | input | 1 | Link good from the PHY core |
| core_jabber | input | 1 | Jabber event |
| core_rfault | input | 1 | Remote fault event |
| core_an_done | input | 1 | Negotiation complete level |
| core_rst_done | input | 1 | Soft reset complete handshake |
| core_an_started | input | 1 | Negotiation started handshake |
| core_lp_word | input | 16 | Link partner ability word from the core |
| strap_speed | input | 1 | Reset value of the speed bit |
| strap_duplex | input | 1 | Reset value of the duplex bit |
| strap_an_en | input | 1 | Reset value of negotiation enable |
| strap_adv | input | 4 | Reset value of advertisement bits 8..5 |
| pdn_pin_n | input | 1 | Active-low power-down pin |
| fiber_en | input | 1 | Fiber mode; forces negotiation off |
| phy_soft_rst | output | 1 | Soft reset request |
| phy_loopback | output | 1 | Loopback enable |
| phy_speed100 | output | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| phy_full_dup | output | 1 | 1 = full duplex |
| phy_an_en | output | 1 | Negotiation enable |
| phy_an_restart | output | 1 | Negotiation restart request |
| phy_pwr_down | output | 1 | Effective power down |
| phy_isolate | output | 1 | Isolate data path |
| phy_col_test | output | 1 | Collision test enable |

## Verification
The hardest situation to reach is a status read that lands in the same cycle as a new fault event. The bench raises the remote fault input at the same falling edge that raises the read strobe. It then checks that the read returned the old value and that the bit is still set afterwards. The link bit's low latch is just as delicate: link good is dropped for a single cycle and restored, and the bench shows that the bit stays 0 until a later read. The masked speed write relies on the stored enable, not the written one, so the stimulus includes a write that turns negotiation off while it tries to change speed.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;
   localparam int REG_AW = 5;
   localparam int REG_DW = 16;

   localparam logic [REG_AW-1:0] ADR_CTRL = 5'd0;
   localparam logic [REG_AW-1:0] ADR_STS  = 5'd1;
   localparam logic [REG_AW-1:0] ADR_ID1  = 5'd2;
   localparam logic [REG_AW-1:0] ADR_ID2  = 5'd3;
   localparam logic [REG_AW-1:0] ADR_ADV  = 5'd4;
   localparam logic [REG_AW-1:0] ADR_LP   = 5'd5;

   // fixed ability bits of the status word
   localparam logic [REG_DW-1:0] STS_FIXED = 16'h78C9;
   // bits whose value never depends on events
   localparam logic [REG_DW-1:0] STS_CONST_MASK = 16'hFFC9;
   localparam logic [REG_DW-1:0] ADV_WR_MASK = 16'hADFF;
   localparam logic [4:0] ADV_SEL_RST = 5'b00001;

   typedef struct packed {
      logic srst;
      logic loop;
      logic spd;
      logic an;
      logic pwr;
      logic iso;
      logic rst_an;
      logic dup;
      logic col;
   } phy_ctrl_t;
endpackage

// File: rtl/phy_sticky_bit.sv
module phy_sticky_bit #(
   parameter bit HOLD_LOW = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic evt,
   input  logic clr,
   output logic q
);
   generate
      if (HOLD_LOW) begin : g_low
         // q = 1 means the condition is good; evt marks a failure
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   q <= 1'b0;
            else if (evt) q <= 1'b0;
            else if (clr) q <= 1'b1;
         end
         // R7
         ll_fail_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
            evt |=> !q);
         // R7
         ll_no_read_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !q && !clr |=> !q);
      end else begin : g_high
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   q <= 1'b0;
            else if (evt) q <= 1'b1;
            else if (clr) q <= 1'b0;
         end
         // R8
         lh_event_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
            evt |=> q);
         // R8
         lh_read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
            q && clr && !evt |=> !q);
      end
   endgenerate
endmodule

// File: rtl/phy_ctrl_reg.sv
module phy_ctrl_reg
   import phy_mgmt_pkg::*;
#(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [DW-1:0] wdata,
   input  logic          strap_spd,
   input  logic          strap_dup,
   input  logic          strap_an,
   input  logic          fiber_en,
   input  logic          pdn_pin_n,
   input  logic          rst_done,
   input  logic          an_started,
   output phy_ctrl_t     ctl,
   output logic [DW-1:0] rd_word
);
   generate
      if (DW != 16) begin : g_dw_bad
         $error("phy_ctrl_reg: DW must be 16");
      end
   endgenerate

   logic reload;
   logic new_an;
   assign reload = ctl.srst & rst_done;
   assign new_an = wdata[12] & ~fiber_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl <= '{srst: 1'b0, loop: 1'b0, spd: strap_spd, an: strap_an & ~fiber_en,
                  pwr: 1'b0, iso: 1'b0, rst_an: 1'b0, dup: strap_dup, col: 1'b0};
      end else if (reload) begin
         ctl <= '{srst: 1'b0, loop: 1'b0, spd: strap_spd, an: strap_an & ~fiber_en,
                  pwr: ~pdn_pin_n, iso: 1'b0, rst_an: 1'b0, dup: strap_dup, col: 1'b0};
      end else begin
         ctl.srst   <= ctl.srst | (wr_en & wdata[15]);
         ctl.rst_an <= (ctl.rst_an & ~an_started) | (wr_en & wdata[9] & new_an);
         if (wr_en) begin
            ctl.loop <= wdata[14];
            ctl.an   <= new_an;
            ctl.pwr  <= wdata[11];
            ctl.iso  <= wdata[10];
            ctl.col  <= wdata[7];
            if (!ctl.an) begin
               ctl.spd <= wdata[13];
               ctl.dup <= wdata[8];
            end
         end
         if (fiber_en)   ctl.an  <= 1'b0;
         if (!pdn_pin_n) ctl.pwr <= 1'b1;
      end
   end

   assign rd_word = {ctl.srst, ctl.loop, ctl.spd, ctl.an, ctl.pwr, ctl.iso,
                     ctl.rst_an, ctl.dup, ctl.col, 7'b0};

   // R2
   srst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl.srst && !rst_done |=> ctl.srst);
   // R2
   srst_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl.srst && rst_done |=> !ctl.srst);
   // R3
   an_restart_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && wdata[9] && !wdata[12] && !ctl.rst_an |=> !ctl.rst_an);
   // R4
   spd_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl.an && !reload |=> $stable(ctl.spd) && $stable(ctl.dup));
   // R5
   pin_sets_pwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pdn_pin_n |=> ctl.pwr);
   // R6
   fiber_an_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fiber_en |=> !ctl.an);
endmodule

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs
   import phy_mgmt_pkg::*;
#(
   parameter int AW = 5,
   parameter int DW = 16,
   parameter logic [5:0] OUI_TAIL = 6'b010111,
   parameter logic [5:0] MODEL_NUM = 6'h0E,
   parameter logic [3:0] MODEL_REV = 4'h1,
   parameter logic [15:0] ID_HIGH = 16'h2000
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] reg_addr,
   input  logic          reg_wr,
   input  logic          reg_rd,
   input  logic [DW-1:0] reg_wdata,
   output logic [DW-1:0] reg_rdata,
   input  logic          core_link_ok,
   input  logic          core_jabber,
   input  logic          core_rfault,
   input  logic          core_an_done,
   input  logic          core_rst_done,
   input  logic          core_an_started,
   input  logic [DW-1:0] core_lp_word,
   input  logic          strap_speed,
   input  logic          strap_duplex,
   input  logic          strap_an_en,
   input  logic [3:0]    strap_adv,
   input  logic          pdn_pin_n,
   input  logic          fiber_en,
   output logic          phy_soft_rst,
   output logic          phy_loopback,
   output logic          phy_speed100,
   output logic          phy_full_dup,
   output logic          phy_an_en,
   output logic          phy_an_restart,
   output logic          phy_pwr_down,
   output logic          phy_isolate,
   output logic          phy_col_test
);
   localparam int NSTICKY = 3;
   // index 0 link (latch low), 1 jabber, 2 remote fault
   localparam logic [NSTICKY-1:0] HOLD_LOW = 3'b001;

   generate
      if (AW != REG_AW || DW != REG_DW) begin : g_size_bad
         $error("phy_mgmt_regs: AW must be 5 and DW must be 16");
      end
   endgenerate

   phy_ctrl_t      ctl;
   logic [DW-1:0]  ctrl_word;
   logic [DW-1:0]  adv_q;
   logic [DW-1:0]  sts_word;
   logic [DW-1:0]  id2_word;
   logic [NSTICKY-1:0] sticky_evt;
   logic [NSTICKY-1:0] sticky_q;
   logic           sts_read;
   logic           reload;

   assign sts_read = reg_rd & (reg_addr == ADR_STS);
   assign reload   = ctl.srst & core_rst_done;

   phy_ctrl_reg #(.DW(DW)) ctrl_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (reg_wr & (reg_addr == ADR_CTRL)),
      .wdata      (reg_wdata),
      .strap_spd  (strap_speed),
      .strap_dup  (strap_duplex),
      .strap_an   (strap_an_en),
      .fiber_en   (fiber_en),
      .pdn_pin_n  (pdn_pin_n),
      .rst_done   (core_rst_done),
      .an_started (core_an_started),
      .ctl        (ctl),
      .rd_word    (ctrl_word)
   );

   assign sticky_evt = {core_rfault, core_jabber, ~core_link_ok};

   generate
      for (genvar i = 0; i < NSTICKY; i++) begin : g_sticky
         phy_sticky_bit #(.HOLD_LOW(HOLD_LOW[i])) bit_i (
            .clk   (clk),
            .rst_n (rst_n),
            .evt   (sticky_evt[i]),
            .clr   (sts_read),
            .q     (sticky_q[i])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         adv_q <= {7'b0, strap_adv, ADV_SEL_RST};
      else if (reload)
         adv_q <= {7'b0, strap_adv, ADV_SEL_RST};
      else if (reg_wr && reg_addr == ADR_ADV)
         adv_q <= reg_wdata & ADV_WR_MASK;
   end

   assign sts_word = STS_FIXED | {10'b0, core_an_done, sticky_q[2], 1'b0,
                                  sticky_q[0], sticky_q[1], 1'b0};
   assign id2_word = {OUI_TAIL, MODEL_NUM, MODEL_REV};

   always_comb begin
      case (reg_addr)
         ADR_CTRL: reg_rdata = ctrl_word;
         ADR_STS:  reg_rdata = sts_word;
         ADR_ID1:  reg_rdata = ID_HIGH;
         ADR_ID2:  reg_rdata = id2_word;
         ADR_ADV:  reg_rdata = adv_q;
         ADR_LP:   reg_rdata = core_lp_word;
         default:  reg_rdata = '0;
      endcase
   end

   assign phy_soft_rst   = ctl.srst;
   assign phy_loopback   = ctl.loop;
   assign phy_speed100   = ctl.spd;
   assign phy_full_dup   = ctl.dup;
   assign phy_an_en      = ctl.an;
   assign phy_an_restart = ctl.rst_an;
   assign phy_pwr_down   = ctl.pwr | ~pdn_pin_n;
   assign phy_isolate    = ctl.iso;
   assign phy_col_test   = ctl.col;

   // R11
   adv_ro_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_addr == ADR_ADV |-> (reg_rdata & ~ADV_WR_MASK) == '0);
   // R9
   sts_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_addr == ADR_STS |-> (reg_rdata & STS_CONST_MASK) == STS_FIXED);
   // R5
   pin_pwr_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pdn_pin_n |-> phy_pwr_down);
   // R3
   restart_needs_an_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(phy_an_restart) |-> phy_an_en);
endmodule

// File: tb/phy_mgmt_regs_tb_top.sv
module phy_mgmt_regs_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [4:0]  reg_addr = '0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic core_link_ok = 1'b0, core_jabber = 1'b0, core_rfault = 1'b0;
   logic core_an_done = 1'b0, core_rst_done = 1'b0, core_an_started = 1'b0;
   logic [15:0] core_lp_word = 16'h4DE1;
   logic strap_speed = 1'b1, strap_duplex = 1'b0, strap_an_en = 1'b1;
   logic [3:0] strap_adv = 4'b1011;
   logic pdn_pin_n = 1'b1, fiber_en = 1'b0;
   logic phy_soft_rst, phy_loopback, phy_speed100, phy_full_dup, phy_an_en;
   logic phy_an_restart, phy_pwr_down, phy_isolate, phy_col_test;

   int total = 0;
   int bad = 0;

   always #2 clk = ~clk;

   phy_mgmt_regs dut_i (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .core_link_ok(core_link_ok),
      .core_jabber(core_jabber), .core_rfault(core_rfault), .core_an_done(core_an_done),
      .core_rst_done(core_rst_done), .core_an_started(core_an_started),
      .core_lp_word(core_lp_word), .strap_speed(strap_speed), .strap_duplex(strap_duplex),
      .strap_an_en(strap_an_en), .strap_adv(strap_adv), .pdn_pin_n(pdn_pin_n),
      .fiber_en(fiber_en), .phy_soft_rst(phy_soft_rst), .phy_loopback(phy_loopback),
      .phy_speed100(phy_speed100), .phy_full_dup(phy_full_dup), .phy_an_en(phy_an_en),
      .phy_an_restart(phy_an_restart), .phy_pwr_down(phy_pwr_down),
      .phy_isolate(phy_isolate), .phy_col_test(phy_col_test)
   );

   typedef struct packed {
      logic [4:0]  addr;
      logic [15:0] wdata;
      logic [15:0] expect_rd;
   } vec_t;

   localparam int NVEC = 10;
   localparam vec_t VEC [NVEC] = '{
      '{5'd4, 16'hFFFF, 16'hADFF},
      '{5'd4, 16'h0000, 16'h0000},
      '{5'd0, 16'h4000, 16'h6000},
      '{5'd0, 16'h2100, 16'h2100},
      '{5'd0, 16'h0000, 16'h0000},
      '{5'd0, 16'h047F, 16'h0400},
      '{5'd0, 16'h0480, 16'h0480},
      '{5'd2, 16'h1234, 16'h2000},
      '{5'd9, 16'hFFFF, 16'h0000},
      '{5'd0, 16'h0000, 16'h0000}
   };

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic peek(input string req, input logic [4:0] a, input logic [15:0] exp);
      reg_addr = a;
      #1;
      chk(req, reg_rdata, exp);
   endtask

   task automatic rd_chk(input string req, input logic [4:0] a, input logic [15:0] exp);
      @(negedge clk);
      reg_addr = a; reg_rd = 1'b1;
      #1;
      chk(req, reg_rdata, exp);
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic pulse(ref logic s);
      @(negedge clk);
      s = 1'b1;
      @(negedge clk);
      s = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog: got hang expected finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      peek("R1 ctrl", 5'd0, 16'h3000);
      peek("R1 adv", 5'd4, 16'h0161);
      peek("R1 status", 5'd1, 16'h78C9);
      chk("R1 outputs", {7'b0, phy_soft_rst, phy_speed100, phy_full_dup, phy_an_en,
          phy_an_restart, phy_pwr_down, phy_loopback, phy_isolate, phy_col_test},
          16'b0000000_0_1_0_1_0_0_0_0_0);

      // R11 R13 R4 register table
      for (int i = 0; i < NVEC; i++) begin
         wr(VEC[i].addr, VEC[i].wdata);
         peek("R11 R13 R4 table", VEC[i].addr, VEC[i].expect_rd);
      end

      // R13 R4 outputs follow bits when negotiation is off
      wr(5'd0, 16'h6180);
      chk("R13 R4 outputs", {12'b0, phy_loopback, phy_speed100, phy_full_dup, phy_col_test},
          16'h000F);
      // R4 mask while negotiation on
      wr(5'd0, 16'h3100);
      wr(5'd0, 16'h1000);
      peek("R4 masked write", 5'd0, 16'h3100);
      chk("R4 outputs kept", {14'b0, phy_speed100, phy_full_dup}, 16'h0003);

      // R3 restart self-clear
      wr(5'd0, 16'h1200);
      peek("R3 restart set", 5'd0, 16'h3300);
      repeat (3) @(negedge clk);
      chk("R3 restart held", {15'b0, phy_an_restart}, 16'h0001);
      pulse(core_an_started);
      peek("R3 restart cleared", 5'd0, 16'h3100);
      wr(5'd0, 16'h0200);
      peek("R3 restart ignored", 5'd0, 16'h2100);
      chk("R3 restart out", {15'b0, phy_an_restart}, 16'h0000);

      // R5 power down
      wr(5'd0, 16'h0800);
      chk("R5 bit pwr", {15'b0, phy_pwr_down}, 16'h0001);
      wr(5'd0, 16'h0000);
      chk("R5 pwr off", {15'b0, phy_pwr_down}, 16'h0000);
      @(negedge clk);
      pdn_pin_n = 1'b0;
      #1;
      chk("R5 pin pwr", {15'b0, phy_pwr_down}, 16'h0001);
      @(negedge clk);
      pdn_pin_n = 1'b1;
      peek("R5 pin set bit", 5'd0, 16'h0800);
      chk("R5 pwr stays", {15'b0, phy_pwr_down}, 16'h0001);
      wr(5'd0, 16'h0000);

      // R2 soft reset
      wr(5'd0, 16'h4000);
      wr(5'd0, 16'h8000);
      peek("R2 srst reads 1", 5'd0, 16'h8000);
      repeat (3) @(negedge clk);
      peek("R2 srst held", 5'd0, 16'h8000);
      chk("R2 srst out", {15'b0, phy_soft_rst}, 16'h0001);
      pulse(core_rst_done);
      peek("R2 ctrl reload", 5'd0, 16'h3000);
      peek("R2 adv reload", 5'd4, 16'h0161);
      chk("R2 srst out clear", {15'b0, phy_soft_rst}, 16'h0000);

      // R6 fiber mode
      @(negedge clk);
      fiber_en = 1'b1;
      @(negedge clk);
      peek("R6 fiber clears an", 5'd0, 16'h2000);
      wr(5'd0, 16'h1000);
      peek("R6 write masked", 5'd0, 16'h0000);
      wr(5'd0, 16'h8000);
      pulse(core_rst_done);
      peek("R6 reload an off", 5'd0, 16'h2000);
      chk("R6 an out", {15'b0, phy_an_en}, 16'h0000);
      @(negedge clk);
      fiber_en = 1'b0;

      // R9 status fixed and live bit
      peek("R9 status", 5'd1, 16'h78C9);
      core_an_done = 1'b1;
      peek("R9 an done", 5'd1, 16'h78E9);

      // R7 link latch low
      core_link_ok = 1'b1;
      @(negedge clk);
      peek("R7 no rise without read", 5'd1, 16'h78E9);
      rd_chk("R7 read", 5'd1, 16'h78E9);
      peek("R7 link up", 5'd1, 16'h78ED);
      pulse(core_link_ok);
      core_link_ok = 1'b1;
      @(negedge clk);
      core_link_ok = 1'b0;
      @(negedge clk);
      core_link_ok = 1'b1;
      @(negedge clk);
      peek("R7 fail latched", 5'd1, 16'h78E9);
      rd_chk("R7 read low", 5'd1, 16'h78E9);
      peek("R7 restored", 5'd1, 16'h78ED);

      // R8 latch high
      pulse(core_jabber);
      peek("R8 jabber set", 5'd1, 16'h78EF);
      rd_chk("R8 jabber read", 5'd1, 16'h78EF);
      peek("R8 jabber cleared", 5'd1, 16'h78ED);
      @(negedge clk);
      reg_addr = 5'd1; reg_rd = 1'b1; core_rfault = 1'b1;
      #1;
      chk("R8 read before event", reg_rdata, 16'h78ED);
      @(negedge clk);
      reg_rd = 1'b0; core_rfault = 1'b0;
      peek("R8 event wins", 5'd1, 16'h78FD);
      rd_chk("R8 rfault read", 5'd1, 16'h78FD);
      peek("R8 rfault cleared", 5'd1, 16'h78ED);

      // R10 identifiers, R12 partner word and unmapped
      peek("R10 id1", 5'd2, 16'h2000);
      peek("R10 id2", 5'd3, 16'h5CE1);
      peek("R12 partner", 5'd5, 16'h4DE1);
      peek("R12 unmapped", 5'd31, 16'h0000);
      wr(5'd1, 16'h0000);
      peek("R11 status write ignored", 5'd1, 16'h78ED);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule